// File: doc/BRIEF.md
# RAID-6 Dual Parity Word Generator

This block produces the two redundancy words of a RAID-6 stripe chunk. The first, P, is the bytewise XOR of every data word. The second, Q, is a Reed-Solomon syndrome over GF(2^8). It is built by Horner accumulation: multiply the running value by two in the field, then XOR in the next data word. Each word is `LANES` bytes wide. Every byte lane is computed on its own, and no carry passes between lanes.

A control pulse opens a stripe and gives the total disk count. That count includes the two parity disks, so the number of data disks is count minus two. The data words then enter on a valid/ready stream, one word per beat. The first word comes from the highest-numbered data disk and the last from disk 0. After the last data beat, P and Q appear together on a valid/ready output. The input stalls until the consumer takes the result. Once the result is taken, both accumulators read zero.

Back-pressure rules:
- An input beat moves only in a cycle where `in_valid_i` and `in_ready_o` are both high.
- `in_ready_o` is high only while a stripe is being collected.
- The result moves only when `out_valid_o` and `out_ready_i` are both high.
- While `out_valid_o` is high and not yet accepted, `p_o` and `q_o` do not change.

Top module: `raid_pq_gen`

## Requirements
- R1: After reset, `out_valid_o`, `in_ready_o` and `err_o` are low, and `p_o` and `q_o` are zero.
- R2: A start with disk count N of 4 or more opens a stripe of N-2 data words. The first accepted word is loaded into both P and Q. `out_valid_o` rises in the cycle after the (N-2)-th beat is accepted.
- R3: P equals the XOR of all N-2 accepted data words.
- R4: For every word after the first, Q becomes mul2(Q) XOR word, in arrival order.
- R5: For one byte, mul2 shifts left by one bit and drops bit 7. When bit 7 was set, it then XORs the result with 0x1d. So 0x80 gives 0x1d, 0xff gives 0xe3 and 0x40 gives 0x80.
- R6: Lane k occupies bits 8k+7:8k of every word, and lanes never affect one another.
- R7: A start with disk count below 4 is rejected. `err_o` is high for exactly the one cycle after that start, and no stripe opens (`in_ready_o` stays low).
- R8: While `out_valid_o` is high and `out_ready_i` is low, `p_o` and `q_o` hold their values and `in_ready_o` is low.
- R9: In the cycle after the result is accepted, `p_o` and `q_o` read zero.
- R10: A start pulse is ignored while a stripe is being collected, and while a result waits unaccepted. This includes raising no error.
- R11: A start pulse in the same cycle as the result handshake opens the next stripe at once.
- R12: Gaps in `in_valid_i` do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Pulse that opens a stripe |
| disk_cnt_i | input | CNT_W | Total disk count, parity disks included, sampled with start_i |
| err_o | output | 1 | One-cycle flag for a rejected disk count |
| in_valid_i | input | 1 | Data word valid |
| in_ready_o | output | 1 | Block accepts a data word |
| in_data_i | input | 8*LANES | Data word, highest disk first |
| out_valid_o | output | 1 | P and Q are valid |
| out_ready_i | input | 1 | Consumer takes P and Q |
| p_o | output | 8*LANES | XOR parity word |
| q_o | output | 8*LANES | GF(2^8) syndrome word |

## Verification
Two events can land in the same cycle: the consumer accepting the finished result, and a start pulse for the next stripe. The bench makes them collide by raising `out_ready_i` and `start_i` together. It then checks that the accumulators read zero on the next cycle and that the input opens immediately. It also checks that the new stripe's P and Q match a model computed from the words alone. A second overlap is a start pulse that arrives mid-stripe. In that case the bench checks that the words already collected, and the result, are unchanged and that no error is raised.

// File: rtl/raid_pq_pkg.sv
package raid_pq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_EMIT    = 2'd2
  } seq_state_t;

  // Low byte of the field polynomial x^8+x^4+x^3+x^2+1
  localparam logic [7:0] GF_POLY_LOW = 8'h1d;
  // Two data disks plus the two parity disks
  localparam int MIN_DISKS = 4;
  localparam int PARITY_DISKS = 2;
endpackage

// File: rtl/gf_mul2_lanes.sv
module gf_mul2_lanes #(
  parameter int LANES = 4,
  localparam int DW = 8 * LANES
) (
  input  logic [DW-1:0] a_i,
  output logic [DW-1:0] y_o
);
  import raid_pq_pkg::*;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] lane_in;
    logic [7:0] sign_mask;
    logic [7:0] shifted;
    assign lane_in   = a_i[l*8 +: 8];
    // A negative signed byte yields an all-ones mask
    assign sign_mask = {8{lane_in[7]}};
    assign shifted   = {lane_in[6:0], 1'b0};
    assign y_o[l*8 +: 8] = shifted ^ (sign_mask & GF_POLY_LOW);
  end
endmodule

// File: rtl/pq_accum.sv
module pq_accum #(
  parameter int LANES = 4,
  localparam int DW = 8 * LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          acc_i,
  input  logic          clear_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] p_o,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] p_q, q_q;
  logic [DW-1:0] q_dbl;

  gf_mul2_lanes #(.LANES(LANES)) u_dbl (
    .a_i (q_q),
    .y_o (q_dbl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_q <= '0;
      q_q <= '0;
    end else if (clear_i) begin
      p_q <= '0;
      q_q <= '0;
    end else if (load_i) begin
      p_q <= data_i;
      q_q <= data_i;
    end else if (acc_i) begin
      p_q <= p_q ^ data_i;
      q_q <= q_dbl ^ data_i;
    end
  end

  assign p_o = p_q;
  assign q_o = q_q;
endmodule

// File: rtl/stripe_seq.sv
module stripe_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] disk_cnt_i,
  input  logic             in_valid_i,
  input  logic             out_ready_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic             err_o,
  output logic             load_o,
  output logic             acc_o,
  output logic             clear_o
);
  import raid_pq_pkg::*;

  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_DISKS);
  localparam logic [CNT_W-1:0] PAR_CNT = CNT_W'(PARITY_DISKS);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic             first_q, first_d;
  logic             err_d, err_q;
  logic             beat, taken, start_seen, cnt_ok;

  assign in_ready_o  = (state_q == ST_COLLECT);
  assign out_valid_o = (state_q == ST_EMIT);
  assign beat        = in_valid_i && in_ready_o;
  assign taken       = out_valid_o && out_ready_i;
  assign start_seen  = start_i && ((state_q == ST_IDLE) || taken);
  assign cnt_ok      = (disk_cnt_i >= MIN_CNT);

  assign load_o  = beat && first_q;
  assign acc_o   = beat && !first_q;
  assign clear_o = taken;

  always_comb begin
    state_d  = state_q;
    remain_d = remain_q;
    first_d  = first_q;
    err_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: ;
      ST_COLLECT: begin
        if (beat) begin
          first_d  = 1'b0;
          remain_d = remain_q - 1'b1;
          if (remain_q == CNT_W'(1)) state_d = ST_EMIT;
        end
      end
      ST_EMIT: begin
        if (taken) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (start_seen) begin
      if (cnt_ok) begin
        state_d  = ST_COLLECT;
        remain_d = disk_cnt_i - PAR_CNT;
        first_d  = 1'b1;
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      first_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      remain_q <= remain_d;
      first_q  <= first_d;
      err_q    <= err_d;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/raid_pq_gen.sv
module raid_pq_gen #(
  parameter int LANES = 4,
  parameter int CNT_W = 8,
  localparam int DW = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] disk_cnt_i,
  output logic             err_o,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [DW-1:0]    in_data_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [DW-1:0]    p_o,
  output logic [DW-1:0]    q_o
);
  logic load, acc, clear;

  stripe_seq #(.CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .disk_cnt_i  (disk_cnt_i),
    .in_valid_i  (in_valid_i),
    .out_ready_i (out_ready_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .err_o       (err_o),
    .load_o      (load),
    .acc_o       (acc),
    .clear_o     (clear)
  );

  pq_accum #(.LANES(LANES)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .acc_i   (acc),
    .clear_i (clear),
    .data_i  (in_data_i),
    .p_o     (p_o),
    .q_o     (q_o)
  );
endmodule

// File: rtl/raid_pq_gen_chk.sv
module raid_pq_gen_chk #(
  parameter int LANES = 4,
  parameter int CNT_W = 8,
  localparam int DW = 8 * LANES
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [CNT_W-1:0] disk_cnt_i,
  input logic             err_o,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [DW-1:0]    p_o,
  input logic [DW-1:0]    q_o
);
  assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(p_o) && $stable(q_o)));

  assert_no_input_while_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid_o && in_ready_o));

  assert_cleared_after_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i) |=> (p_o == '0 && q_o == '0));

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(start_i && (disk_cnt_i < CNT_W'(4))));

  assert_err_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o || $past(start_i));

  assert_result_after_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid_o) |-> $past(in_valid_i && in_ready_o));
endmodule

bind raid_pq_gen raid_pq_gen_chk #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .disk_cnt_i  (disk_cnt_i),
  .err_o       (err_o),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .p_o         (p_o),
  .q_o         (q_o)
);

// File: tb/raid_pq_gen_tb.sv
module raid_pq_gen_tb;
  localparam int LANES = 4;
  localparam int CNT_W = 8;
  localparam int DW = 8 * LANES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [CNT_W-1:0] disk_cnt_i = '0;
  logic err_o;
  logic in_valid_i = 1'b0;
  logic in_ready_o;
  logic [DW-1:0] in_data_i = '0;
  logic out_valid_o;
  logic out_ready_i = 1'b0;
  logic [DW-1:0] p_o, q_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  raid_pq_gen #(.LANES(LANES), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .disk_cnt_i(disk_cnt_i),
    .err_o(err_o), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_data_i(in_data_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .p_o(p_o), .q_o(q_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  function automatic logic [DW-1:0] dbl(input logic [DW-1:0] w);
    logic [DW-1:0] r;
    for (int l = 0; l < LANES; l++) begin
      r[l*8 +: 8] = {w[l*8 +: 7], 1'b0} ^ (w[l*8+7] ? 8'h1d : 8'h00);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input int cnt);
    start_i = 1'b1;
    disk_cnt_i = CNT_W'(cnt);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send(input logic [DW-1:0] w, input int gap);
    for (int g = 0; g < gap; g++) @(negedge clk);
    in_valid_i = 1'b1;
    in_data_i = w;
    while (!in_ready_o) @(negedge clk);
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  task automatic take(input string req, input logic [DW-1:0] ep, input logic [DW-1:0] eq);
    while (!out_valid_o) @(negedge clk);
    chk({req, " P"}, p_o, ep);
    chk({req, " Q"}, q_o, eq);
    out_ready_i = 1'b1;
    @(negedge clk);
    out_ready_i = 1'b0;
    chk("R9 P cleared", p_o, '0);
    chk("R9 Q cleared", q_o, '0);
  endtask

  task automatic run_stripe(input string req, input int cnt,
                            input logic [DW-1:0] w [8], input int gap);
    logic [DW-1:0] ep, eq;
    ep = w[0];
    eq = w[0];
    for (int i = 1; i < cnt - 2; i++) begin
      ep = ep ^ w[i];
      eq = dbl(eq) ^ w[i];
    end
    pulse_start(cnt);
    for (int i = 0; i < cnt - 2; i++) begin
      send(w[i], gap);
      if (i < cnt - 3) chk("R2 no early result", DW'(out_valid_o), DW'(0));
    end
    chk("R2 result valid after last beat", DW'(out_valid_o), DW'(1));
    take(req, ep, eq);
  endtask

  task automatic t_reset();
    chk("R1 out_valid", DW'(out_valid_o), '0);
    chk("R1 in_ready", DW'(in_ready_o), '0);
    chk("R1 err", DW'(err_o), '0);
    chk("R1 P", p_o, '0);
    chk("R1 Q", q_o, '0);
  endtask

  task automatic t_mul2_literal();
    logic [DW-1:0] w [8];
    w = '{default: '0};
    w[0] = 32'h80ff4001;
    // R5: 0x80->1d, 0xff->e3, 0x40->80, 0x01->02
    run_stripe("R5 mul2 literal", 4, w, 0);
  endtask

  task automatic t_literal_q();
    logic [DW-1:0] w [8];
    w = '{default: '0};
    w[0] = 32'h80ff4001;
    pulse_start(4);
    send(w[0], 0);
    send('0, 0);
    chk("R5 Q literal", q_o, 32'h1de38002);
    chk("R3 P literal", p_o, 32'h80ff4001);
    out_ready_i = 1'b1;
    @(negedge clk);
    out_ready_i = 1'b0;
  endtask

  task automatic t_lanes();
    logic [DW-1:0] w [8];
    w = '{default: '0};
    w[0] = 32'h80000000;
    pulse_start(6);
    for (int i = 0; i < 4; i++) send(w[i], 0);
    // R6: lane 3 doubled three times: 80->1d->3a->74, other lanes stay zero
    chk("R6 lane isolation Q", q_o, 32'h74000000);
    chk("R6 lane isolation P", p_o, 32'h80000000);
    out_ready_i = 1'b1;
    @(negedge clk);
    out_ready_i = 1'b0;
  endtask

  task automatic t_long();
    logic [DW-1:0] w [8];
    w = '{32'hdeadbeef, 32'h01234567, 32'h89abcdef, 32'hfedcba98,
          32'h7f807f80, 32'hffffffff, 32'h00000000, 32'h5a5aa5a5};
    run_stripe("R4 eight data disks", 10, w, 0);
    w = '{32'h11223344, 32'hc0c0c0c0, 32'h0f0f0f0f, 32'h8181ff00,
          32'h0, 32'h0, 32'h0, 32'h0};
    run_stripe("R3 four data disks", 6, w, 0);
  endtask

  task automatic t_gaps();
    logic [DW-1:0] w [8];
    w = '{32'h13579bdf, 32'h2468ace0, 32'h80808080, 32'h0badf00d,
          32'h9, 32'h0, 32'h0, 32'h0};
    run_stripe("R12 valid gaps", 7, w, 3);
  endtask

  task automatic t_bad_count();
    for (int c = 0; c < 4; c++) begin
      pulse_start(c);
      chk("R7 err raised", DW'(err_o), DW'(1));
      chk("R7 no stripe opened", DW'(in_ready_o), DW'(0));
      @(negedge clk);
      chk("R7 err one cycle", DW'(err_o), DW'(0));
    end
  endtask

  task automatic t_backpressure();
    logic [DW-1:0] a, b, c;
    a = 32'hc3c3c3c3; b = 32'h12345678; c = 32'h80000001;
    pulse_start(5);
    send(a, 0); send(b, 0); send(c, 0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R8 valid held", DW'(out_valid_o), DW'(1));
      chk("R8 input stalled", DW'(in_ready_o), DW'(0));
      chk("R8 P held", p_o, a ^ b ^ c);
      chk("R8 Q held", q_o, dbl(dbl(a) ^ b) ^ c);
    end
    // R10: start while result pending is ignored
    pulse_start(9);
    chk("R10 no err while pending", DW'(err_o), DW'(0));
    take("R10 result kept", a ^ b ^ c, dbl(dbl(a) ^ b) ^ c);
    chk("R10 ignored start opened nothing", DW'(in_ready_o), DW'(0));
  endtask

  task automatic t_start_mid();
    logic [DW-1:0] a, b, c, d;
    a = 32'h0f1e2d3c; b = 32'h8899aabb; c = 32'hff00ff00; d = 32'h00000080;
    pulse_start(6);
    send(a, 0); send(b, 0);
    pulse_start(4);
    pulse_start(2);
    chk("R10 no err mid-stripe", DW'(err_o), DW'(0));
    send(c, 0);
    chk("R10 still collecting", DW'(out_valid_o), DW'(0));
    send(d, 0);
    take("R10 start ignored mid-stripe", a ^ b ^ c ^ d,
         dbl(dbl(dbl(a) ^ b) ^ c) ^ d);
  endtask

  task automatic t_back_to_back();
    logic [DW-1:0] a, b, c, d, e;
    a = 32'h80808080; b = 32'h01010101;
    c = 32'hfe01fe01; d = 32'h7777aaaa; e = 32'h80000000;
    pulse_start(4);
    send(a, 0); send(b, 0);
    while (!out_valid_o) @(negedge clk);
    chk("R11 first P", p_o, a ^ b);
    chk("R11 first Q", q_o, dbl(a) ^ b);
    out_ready_i = 1'b1;
    start_i = 1'b1;
    disk_cnt_i = CNT_W'(5);
    @(negedge clk);
    out_ready_i = 1'b0;
    start_i = 1'b0;
    chk("R11 next stripe open", DW'(in_ready_o), DW'(1));
    chk("R11 accum cleared P", p_o, '0);
    chk("R11 accum cleared Q", q_o, '0);
    send(c, 0); send(d, 0); send(e, 0);
    take("R11 second stripe", c ^ d ^ e, dbl(dbl(c) ^ d) ^ e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_literal_q();
    t_mul2_literal();
    t_lanes();
    t_long();
    t_gaps();
    t_bad_count();
    t_backpressure();
    t_start_mid();
    t_back_to_back();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule